// File: doc/BRIEF.md
# Raster Timing Generator with Dot/Line Interrupt

This block produces the horizontal and vertical position of an NTSC-style raster from a master clock. Every master clock is one master cycle. A scanline holds 340 dot positions. Most dots last 4 master cycles, but two dots near the end of the line are stretched to 6 master cycles, which gives a line of 1364 master cycles. A normal frame holds scanlines 0 to 261. A frame parity bit alternates from frame to frame. On odd-parity frames the pattern depends on the interlace setting. Without interlace, one scanline drops its stretch and is 4 master cycles shorter. With interlace, the frame gains an extra scanline.

An interrupt comparator runs beside the counters. It has a programmable dot target, a programmable line target and two enable bits. The comparator does not follow the real, stretched dot positions. It counts an idealised line in which every dot lasts 4 master cycles. Because of that, and because it is blanked in a few places, some targets can never be reached. When the enabled targets match, the block emits a pulse one master cycle long. A dot strobe marks the first master cycle of every real dot, so that downstream pixel logic can step in step with the counters.

Top module: `raster_timing`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the dot counter, the line counter and the parity bit to 0 and selects non-interlaced frames. While `rst` is high, `irqPulse` and `dotStrobe` are low.
- R2: `hCount` counts 0 to 339. Dots 323 and 327 last 6 master cycles and every other dot lasts 4, so a normal line is 1364 master cycles long.
- R3: On a non-interlaced frame with parity 1, dots 323 and 327 of scanline 240 last 4 master cycles, so that line is 1360 master cycles long.
- R4: `vCount` counts 0 to 261. On an interlaced frame with parity 1 an extra scanline 262 follows before the wrap.
- R5: `frameParity` toggles only when the counters wrap from the last scanline to scanline 0. The `interlaceMode` input (1 = interlaced) is sampled only at that wrap. A change during a frame does not alter that frame.
- R6: `dotStrobe` is high exactly on the first master cycle of each dot.
- R7: The comparator places idealised dot k at master cycle 4k of the line, counted from the first master cycle of dot 0. A pulse can occur only on such a cycle, and only for k from 0 to 339.
- R8: `irqMode` bit 0 enables the dot target and bit 1 enables the line target. Mode 01 fires on every line at idealised dot `irqHTarget`. Mode 10 fires at idealised dot 0 of line `irqVTarget`. Mode 11 fires at dot `irqHTarget` of line `irqVTarget`. Mode 00 never fires.
- R9: `irqPulse` is never high for two master cycles in a row.
- R10: When the dot target is enabled, an `irqHTarget` of 340 or more never fires.
- R11: When the dot target is enabled, an `irqHTarget` of 153 does not fire on the shortened scanline or on the last scanline of the frame (261, or 262 on a long interlaced frame).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, one master cycle per edge |
| rst | input | 1 | Synchronous reset, active high |
| interlaceMode | input | 1 | 1 = interlaced frames, sampled at the frame wrap |
| irqMode | input | 2 | Bit 0 dot target enable, bit 1 line target enable |
| irqHTarget | input | 9 | Interrupt dot target |
| irqVTarget | input | 9 | Interrupt line target |
| hCount | output | 9 | Current dot within the line |
| vCount | output | 9 | Current scanline within the frame |
| frameParity | output | 1 | Frame parity bit |
| dotStrobe | output | 1 | High on the first master cycle of each dot |
| irqPulse | output | 1 | One-master-cycle interrupt pulse |

## Verification
The assertions assume that reset is held for at least one clock edge before any check counts. They also assume that the targets and the mode seen in a cycle are the values the comparator uses in that same cycle, since the pulse follows those inputs without a register. The stimulus therefore changes the mode, the targets and the interlace request only just after a clock edge, and only at frame or line starts. The one exception is a single interlace request made in the middle of a frame, which tests that it is sampled only at the wrap. The bench shortens the frame to twelve scanlines, with the shortened line at 7, so that eight frames fit in the run. The full 340-dot line and the stretch positions are kept.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Strobes from the sequencing control to the counter datapath
  typedef struct packed {
    logic dotEnd;    // last master cycle of the current dot
    logic lineEnd;   // last master cycle of the current line
    logic frameEnd;  // last master cycle of the current frame
  } rasterStrobe_t;

  // Interrupt enable encoding: bit 0 dot target, bit 1 line target
  typedef enum logic [1:0] {
    IRQ_OFF  = 2'b00,
    IRQ_DOT  = 2'b01,
    IRQ_LINE = 2'b10,
    IRQ_BOTH = 2'b11
  } irqMode_e;

  function automatic int unsigned widthFor(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int unsigned DOTS_PER_LINE   = 340,
  parameter int unsigned LINES_PER_FRAME = 262,
  parameter int unsigned BASE_DOT_CYCLES = 4,
  parameter int unsigned LONG_DOT_CYCLES = 6,
  parameter int unsigned STRETCH_COUNT   = 2,
  parameter logic [16*STRETCH_COUNT-1:0] STRETCH_LIST = {16'd327, 16'd323},
  parameter int unsigned SHORT_LINE      = 240,
  parameter int unsigned H_W             = 9,
  parameter int unsigned V_W             = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [H_W-1:0] hCount,
  input  logic [V_W-1:0] vCount,
  input  logic           frameParity,
  input  logic           interlaceLat,
  output rasterStrobe_t  strobe,
  output logic           dotStart,
  output logic           shortLine,
  output logic           lastLine
);

  localparam int unsigned SUB_W = widthFor(LONG_DOT_CYCLES);

  logic [SUB_W-1:0]         subCount;
  logic [SUB_W-1:0]         dotLast;
  logic [STRETCH_COUNT-1:0] stretchHit;
  logic                     stretched;
  logic                     longFrame;
  logic                     dotEnd;
  logic                     lineEnd;

  // One comparator per stretched dot position
  for (genvar i = 0; i < STRETCH_COUNT; i++) begin : gStretch
    assign stretchHit[i] = (hCount == H_W'(STRETCH_LIST[i*16 +: 16]));
  end

  assign longFrame = interlaceLat && frameParity;
  assign shortLine = !interlaceLat && frameParity && (vCount == V_W'(SHORT_LINE));
  assign lastLine  = longFrame ? (vCount == V_W'(LINES_PER_FRAME))
                               : (vCount == V_W'(LINES_PER_FRAME - 1));
  assign stretched = (|stretchHit) && !shortLine;
  assign dotLast   = stretched ? SUB_W'(LONG_DOT_CYCLES - 1) : SUB_W'(BASE_DOT_CYCLES - 1);

  assign dotEnd  = !rst && (subCount == dotLast);
  assign lineEnd = dotEnd && (hCount == H_W'(DOTS_PER_LINE - 1));

  always_comb begin
    strobe.dotEnd   = dotEnd;
    strobe.lineEnd  = lineEnd;
    strobe.frameEnd = lineEnd && lastLine;
  end

  assign dotStart = !rst && (subCount == '0);

  always_ff @(posedge clk) begin
    if (rst || dotEnd) begin
      subCount <= '0;
    end else begin
      subCount <= subCount + 1'b1;
    end
  end

endmodule

// File: rtl/raster_datapath.sv
module raster_datapath
  import raster_pkg::*;
#(
  parameter int unsigned H_W = 9,
  parameter int unsigned V_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  rasterStrobe_t  strobe,
  input  logic           interlaceMode,
  output logic [H_W-1:0] hCount,
  output logic [V_W-1:0] vCount,
  output logic           frameParity,
  output logic           interlaceLat
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
    end else if (strobe.lineEnd) begin
      hCount <= '0;
    end else if (strobe.dotEnd) begin
      hCount <= hCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vCount       <= '0;
      frameParity  <= 1'b0;
      interlaceLat <= 1'b0;
    end else if (strobe.frameEnd) begin
      vCount       <= '0;
      frameParity  <= !frameParity;
      interlaceLat <= interlaceMode;
    end else if (strobe.lineEnd) begin
      vCount <= vCount + 1'b1;
    end
  end

endmodule

// File: rtl/raster_irq.sv
module raster_irq
  import raster_pkg::*;
#(
  parameter int unsigned DOTS_PER_LINE   = 340,
  parameter int unsigned BASE_DOT_CYCLES = 4,
  parameter int unsigned BLANK_DOT       = 153,
  parameter int unsigned H_W             = 9,
  parameter int unsigned V_W             = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lineEnd,
  input  logic [V_W-1:0] vCount,
  input  logic           shortLine,
  input  logic           lastLine,
  input  logic [1:0]     irqMode,
  input  logic [H_W-1:0] hTarget,
  input  logic [V_W-1:0] vTarget,
  output logic           irqPulse
);

  localparam int unsigned IS_W = widthFor(BASE_DOT_CYCLES);
  localparam int unsigned ID_W = H_W + 1;

  logic [IS_W-1:0] idealSub;
  logic [ID_W-1:0] idealDot;
  logic            hEn;
  logic            vEn;
  logic            onDot;
  logic            hHit;
  logic            vHit;
  logic            blanked;

  // Idealised dot counter: every dot is BASE_DOT_CYCLES long
  always_ff @(posedge clk) begin
    if (rst || lineEnd) begin
      idealSub <= '0;
      idealDot <= '0;
    end else if (idealSub == IS_W'(BASE_DOT_CYCLES - 1)) begin
      idealSub <= '0;
      idealDot <= idealDot + 1'b1;
    end else begin
      idealSub <= idealSub + 1'b1;
    end
  end

  assign hEn     = irqMode[0];
  assign vEn     = irqMode[1];
  assign onDot   = (idealSub == '0) && (idealDot < ID_W'(DOTS_PER_LINE));
  assign hHit    = hEn ? (idealDot == {1'b0, hTarget}) : (idealDot == '0);
  assign vHit    = !vEn || (vCount == vTarget);
  assign blanked = hEn && (hTarget == H_W'(BLANK_DOT)) && (shortLine || lastLine);

  assign irqPulse = !rst && (hEn || vEn) && onDot && hHit && vHit && !blanked;

endmodule

// File: rtl/raster_timing.sv
module raster_timing
  import raster_pkg::*;
#(
  parameter int unsigned DOTS_PER_LINE   = 340,
  parameter int unsigned LINES_PER_FRAME = 262,
  parameter int unsigned BASE_DOT_CYCLES = 4,
  parameter int unsigned LONG_DOT_CYCLES = 6,
  parameter int unsigned STRETCH_COUNT   = 2,
  parameter logic [16*STRETCH_COUNT-1:0] STRETCH_LIST = {16'd327, 16'd323},
  parameter int unsigned SHORT_LINE      = 240,
  parameter int unsigned BLANK_DOT       = 153,
  localparam int unsigned H_W = $clog2(DOTS_PER_LINE + 1),
  localparam int unsigned V_W = $clog2(LINES_PER_FRAME + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           interlaceMode,
  input  logic [1:0]     irqMode,
  input  logic [H_W-1:0] irqHTarget,
  input  logic [V_W-1:0] irqVTarget,
  output logic [H_W-1:0] hCount,
  output logic [V_W-1:0] vCount,
  output logic           frameParity,
  output logic           dotStrobe,
  output logic           irqPulse
);

  rasterStrobe_t strobe;
  logic          interlaceLat;
  logic          shortLine;
  logic          lastLine;

  raster_ctrl #(
    .DOTS_PER_LINE  (DOTS_PER_LINE),
    .LINES_PER_FRAME(LINES_PER_FRAME),
    .BASE_DOT_CYCLES(BASE_DOT_CYCLES),
    .LONG_DOT_CYCLES(LONG_DOT_CYCLES),
    .STRETCH_COUNT  (STRETCH_COUNT),
    .STRETCH_LIST   (STRETCH_LIST),
    .SHORT_LINE     (SHORT_LINE),
    .H_W            (H_W),
    .V_W            (V_W)
  ) uCtrl (
    .clk         (clk),
    .rst         (rst),
    .hCount      (hCount),
    .vCount      (vCount),
    .frameParity (frameParity),
    .interlaceLat(interlaceLat),
    .strobe      (strobe),
    .dotStart    (dotStrobe),
    .shortLine   (shortLine),
    .lastLine    (lastLine)
  );

  raster_datapath #(
    .H_W(H_W),
    .V_W(V_W)
  ) uData (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .interlaceMode(interlaceMode),
    .hCount       (hCount),
    .vCount       (vCount),
    .frameParity  (frameParity),
    .interlaceLat (interlaceLat)
  );

  raster_irq #(
    .DOTS_PER_LINE  (DOTS_PER_LINE),
    .BASE_DOT_CYCLES(BASE_DOT_CYCLES),
    .BLANK_DOT      (BLANK_DOT),
    .H_W            (H_W),
    .V_W            (V_W)
  ) uIrq (
    .clk      (clk),
    .rst      (rst),
    .lineEnd  (strobe.lineEnd),
    .vCount   (vCount),
    .shortLine(shortLine),
    .lastLine (lastLine),
    .irqMode  (irqMode),
    .hTarget  (irqHTarget),
    .vTarget  (irqVTarget),
    .irqPulse (irqPulse)
  );

endmodule

// File: rtl/raster_timing_checker.sv
module raster_timing_checker #(
  parameter int unsigned DOTS_PER_LINE   = 340,
  parameter int unsigned LINES_PER_FRAME = 262,
  parameter int unsigned H_W             = 9,
  parameter int unsigned V_W             = 9
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     irqMode,
  input logic [H_W-1:0] irqHTarget,
  input logic [H_W-1:0] hCount,
  input logic [V_W-1:0] vCount,
  input logic           frameParity,
  input logic           dotStrobe,
  input logic           irqPulse
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |-> (!irqPulse && !dotStrobe));

  assert_h_range_R2: assert property (@(posedge clk) disable iff (rst)
    hCount < H_W'(DOTS_PER_LINE));

  assert_h_on_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(hCount) |-> dotStrobe);

  assert_v_range_R4: assert property (@(posedge clk) disable iff (rst)
    vCount <= V_W'(LINES_PER_FRAME));

  assert_parity_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(frameParity) |-> (vCount == '0 && hCount == '0 && dotStrobe));

  assert_strobe_gap_R6: assert property (@(posedge clk) disable iff (rst)
    dotStrobe |=> !dotStrobe);

  assert_irq_needs_mode_R8: assert property (@(posedge clk) disable iff (rst)
    irqPulse |-> (irqMode != 2'b00));

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
    irqPulse |=> !irqPulse);

  assert_no_far_target_R10: assert property (@(posedge clk) disable iff (rst)
    (irqMode[0] && irqHTarget >= H_W'(DOTS_PER_LINE)) |-> !irqPulse);

endmodule

bind raster_timing raster_timing_checker #(
  .DOTS_PER_LINE  (DOTS_PER_LINE),
  .LINES_PER_FRAME(LINES_PER_FRAME),
  .H_W            (H_W),
  .V_W            (V_W)
) uChk (
  .clk        (clk),
  .rst        (rst),
  .irqMode    (irqMode),
  .irqHTarget (irqHTarget),
  .hCount     (hCount),
  .vCount     (vCount),
  .frameParity(frameParity),
  .dotStrobe  (dotStrobe),
  .irqPulse   (irqPulse)
);

// File: tb/sim_raster_timing.sv
module sim_raster_timing;

  localparam int CLK_PERIOD = 10;
  localparam int DOTS       = 340;
  localparam int LINES      = 12;
  localparam int SHORT      = 7;
  localparam int H_W        = 9;
  localparam int V_W        = 4;
  localparam int NF         = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           il  = 1'b0;
  logic [1:0]     mode = 2'b00;
  logic [H_W-1:0] hT = '0;
  logic [V_W-1:0] vT = '0;
  logic [H_W-1:0] hCount;
  logic [V_W-1:0] vCount;
  logic           frameParity;
  logic           dotStrobe;
  logic           irqPulse;

  raster_timing #(
    .LINES_PER_FRAME(LINES),
    .SHORT_LINE     (SHORT)
  ) u0 (
    .clk          (clk),
    .rst          (rst),
    .interlaceMode(il),
    .irqMode      (mode),
    .irqHTarget   (hT),
    .irqVTarget   (vT),
    .hCount       (hCount),
    .vCount       (vCount),
    .frameParity  (frameParity),
    .dotStrobe    (dotStrobe),
    .irqPulse     (irqPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit started = 0;

  // Behavioural reference state
  int mCyc = 0, mLine = 0, mPar = 0, mIl = 0, frameNo = 0;
  int pulses [NF];
  int shortCyc [NF];
  int maxV [NF];
  int doubles = 0;
  bit prevIrq = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic bit shortNow();
    return (mIl == 0) && (mPar == 1) && (mLine == SHORT);
  endfunction

  function automatic int lastIdx();
    return (mIl == 1 && mPar == 1) ? LINES : LINES - 1;
  endfunction

  function automatic int lineLen();
    return shortNow() ? 1360 : 1364;
  endfunction

  // Real dot index at a cycle of the line, closed form
  function automatic int dotOf(input int c, input bit sh);
    if (sh || c < 1292) return c / 4;
    if (c < 1298) return 323;
    if (c < 1310) return 324 + (c - 1298) / 4;
    if (c < 1316) return 327;
    return 328 + (c - 1316) / 4;
  endfunction

  function automatic bit expStrobe();
    if (rst) return 0;
    if (mCyc == 0) return 1;
    return dotOf(mCyc, shortNow()) != dotOf(mCyc - 1, shortNow());
  endfunction

  function automatic bit expIrq();
    int id;
    bit hitH, hitV;
    if (rst || mode == 2'b00 || (mCyc % 4) != 0) return 0;
    id = mCyc / 4;
    if (id >= DOTS) return 0;
    hitH = mode[0] ? (id == int'(hT)) : (id == 0);
    hitV = mode[1] ? (mLine == int'(vT)) : 1'b1;
    if (mode[0] && int'(hT) == 153 && (shortNow() || mLine == lastIdx())) return 0;
    return hitH && hitV;
  endfunction

  // Advance the reference model on every edge
  always @(posedge clk) begin
    if (rst) begin
      mCyc = 0; mLine = 0; mPar = 0; mIl = 0; started = 1;
    end else begin
      mCyc = mCyc + 1;
      if (mCyc == lineLen()) begin
        mCyc = 0;
        if (mLine == lastIdx()) begin
          mLine = 0; mPar = 1 - mPar; mIl = int'(il); frameNo = frameNo + 1;
        end else begin
          mLine = mLine + 1;
        end
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk(int'(hCount) == (rst ? 0 : dotOf(mCyc, shortNow())), "R2 hCount", int'(hCount),
          rst ? 0 : dotOf(mCyc, shortNow()));
      chk(int'(vCount) == mLine, "R4 vCount", int'(vCount), mLine);
      chk(int'(frameParity) == mPar, "R5 frameParity", int'(frameParity), mPar);
      chk(dotStrobe == expStrobe(), "R6 dotStrobe", int'(dotStrobe), int'(expStrobe()));
      chk(irqPulse == expIrq(), "R7 irqPulse", int'(irqPulse), int'(expIrq()));
      if (!rst && frameNo < NF) begin
        if (irqPulse) pulses[frameNo]++;
        if (int'(vCount) == SHORT) shortCyc[frameNo]++;
        if (int'(vCount) > maxV[frameNo]) maxV[frameNo] = int'(vCount);
      end
      if (irqPulse && prevIrq) doubles++;
      prevIrq = irqPulse;
      if (errors >= 40) finishRun();
    end
  end

  task automatic waitFrame(input int k);
    do begin @(posedge clk); #1; end while (frameNo < k && !done);
  endtask

  task automatic waitLine(input int l);
    do begin @(posedge clk); #1; end while (mLine < l && !done);
  endtask

  initial begin
    int expPulse [8] = '{11, 10, 11, 5, 0, 1, 1, 0};
    for (int f = 0; f < NF; f++) begin pulses[f] = 0; shortCyc[f] = 0; maxV[f] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(hCount == '0 && vCount == '0, "R1 reset counters", int'(hCount) + int'(vCount), 0);
    chk(!frameParity && !irqPulse && !dotStrobe, "R1 reset outputs",
        int'(frameParity) + int'(irqPulse) + int'(dotStrobe), 0);
    @(posedge clk); #1;
    rst = 0; mode = 2'b01; hT = 9'd153; vT = '0; il = 0;
    // Frame 3: interlace requested mid-frame, then mode both at line 5
    waitFrame(3);
    waitLine(5);
    il = 1; mode = 2'b11; vT = 4'd11;
    waitFrame(6);
    mode = 2'b10; vT = 4'd3; il = 0;
    waitFrame(7);
    mode = 2'b01; hT = 9'd340;
    waitFrame(8);
    for (int f = 0; f < 8; f++) begin
      chk(pulses[f] == expPulse[f],
          (f == 7) ? "R10 pulses frame 7" : (f == 3 || f == 5 || f == 6) ? "R8 pulses per frame"
                   : "R11 pulses per frame", pulses[f], expPulse[f]);
    end
    chk(shortCyc[0] == 1364, "R2 line length frame 0", shortCyc[0], 1364);
    chk(shortCyc[1] == 1360, "R3 short line frame 1", shortCyc[1], 1360);
    chk(shortCyc[3] == 1360, "R5 mid-frame interlace ignored", shortCyc[3], 1360);
    chk(shortCyc[5] == 1364, "R4 no short line when interlaced", shortCyc[5], 1364);
    chk(shortCyc[7] == 1360, "R3 short line frame 7", shortCyc[7], 1360);
    chk(maxV[3] == 11, "R5 frame 3 last line", maxV[3], 11);
    chk(maxV[4] == 11, "R4 even interlaced frame last line", maxV[4], 11);
    chk(maxV[5] == 12, "R4 long frame extra line", maxV[5], 12);
    chk(doubles == 0, "R9 consecutive pulses", doubles, 0);
    // Reset in the middle of a run
    waitLine(3);
    rst = 1; mode = 2'b01; hT = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(hCount == '0 && vCount == '0 && !frameParity, "R1 mid-run reset",
        int'(hCount) + int'(vCount) + int'(frameParity), 0);
    chk(!irqPulse && !dotStrobe, "R1 quiet during reset", int'(irqPulse) + int'(dotStrobe), 0);
    @(posedge clk); #1;
    rst = 0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", frameNo, 8);
      finishRun();
    end
  end

endmodule